// File: doc/BRIEF.md
# Peripheral Clock Channel Controller

This block holds a bank of clock channels, one per peripheral. Each channel picks one of several clock generators and drives a clock-enable output in the generic clock domain. That output gates the chosen generator's clock toward one peripheral. Software writes and reads each channel through a simple register port in the bus clock domain. Every channel has its own word address, and each word holds a generator-select field and a run bit.

The run bit crosses from the bus domain into the generic clock domain through a toggle handshake. While a crossing is in flight, the channel reports busy. During that time the run bit on readback keeps its old value, and any further write to that channel is refused and reported on an error output. The generator-select field can be written only while the channel is stopped and idle. The generic-clock side captures the select value together with the run bit, so both settle in that domain as a pair. The clock-enable output is high only when the synchronized run bit is set and the selected generator reports that it is on.

Top module: `pclk_chan_ctrl`

## Requirements
- R1: After reset, every channel reads a select field of 0, a run bit of 0 and busy 0, and every clock-enable output is 0.
- R2: A write to word address c (0 to N_CHAN-1) on a stopped, idle channel stores select value s (any of 0 to N_GEN-1) in channel c. The value shows on rd_sel_o on the cycle after the write when rd_addr_i is c.
- R3: An accepted write whose run value differs from the channel's current run bit sets that channel's busy on the next bus cycle. rd_run_o keeps the old value for as long as busy is 1.
- R4: Busy lasts through a full round trip: two generic-clock synchronizer stages plus a capture stage, then two bus-clock stages. That is at least 4 bus cycles. rd_run_o takes the new value in the same cycle that busy clears.
- R5: A write to a busy channel changes nothing in that channel, and wr_err_o reads 1 after it. Any write to a channel that is not busy leaves wr_err_o at 0. wr_err_o holds between writes.
- R6: The select field of a running channel (run bit 1) is not changed by a write. This holds even when the same write stops the channel.
- R7: The clock-enable output of channel c equals the synchronized run bit ANDed with gen_on_i[select]. It is registered once in the generic clock domain, so it stays 0 whenever the selected generator is off.
- R8: A write whose run value equals the current run bit starts no handshake, and busy stays 0.
- R9: Channels are independent. A write to one channel leaves the readback and the clock enable of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register interface clock |
| bus_rst_n | input | 1 | Bus domain asynchronous active-low reset |
| gclk | input | 1 | Generic clock domain clock |
| gclk_rst_n | input | 1 | Generic domain asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe, one bus cycle per write |
| wr_addr_i | input | ADDR_W | Channel index of the write |
| wr_sel_i | input | SEL_W | Generator select value to write |
| wr_run_i | input | 1 | Run bit value to write |
| wr_err_o | output | 1 | Last write was refused because the channel was busy |
| rd_addr_i | input | ADDR_W | Channel index for readback |
| rd_sel_o | output | SEL_W | Select field of the addressed channel |
| rd_run_o | output | 1 | Committed run bit of the addressed channel |
| rd_busy_o | output | 1 | Crossing in flight for the addressed channel |
| gen_on_i | input | N_GEN | Per-generator running flags, generic domain |
| chan_ce_o | output | N_CHAN | Per-channel clock-enable outputs, generic domain |

## Verification
The bench builds the block with its defaults: 8 generators and 16 channels. The 3-bit select field therefore reaches every generator index, and the 4-bit address reaches every channel. The bus clock runs at 5 ns and the generic clock at an unrelated 7.3 ns, so the edge phase between the domains keeps shifting. The busy window is therefore tested over many alignments rather than one fixed latency. Random writes across all 16 channels mix with random generator on/off patterns. Directed cases cover a write to a busy channel, a select change on a running channel, and an enable whose generator is off.

// File: rtl/pclk_pkg.sv
package pclk_pkg;
  parameter int unsigned DEF_GENS  = 8;
  parameter int unsigned DEF_CHANS = 16;
  parameter int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/pclk_rst_sync.sv
module pclk_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [pclk_pkg::SYNC_STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[pclk_pkg::SYNC_STAGES-2:0], 1'b1};
  end

  assign rst_n = chain_q[pclk_pkg::SYNC_STAGES-1];
endmodule

// File: rtl/pclk_chan_bus.sv
module pclk_chan_bus #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [SEL_W-1:0] wsel,
  input  logic             wrun,
  input  logic             ack_tgl,
  output logic [SEL_W-1:0] sel_q,
  output logic             run_q,
  output logic             busy_q,
  output logic             pend_q,
  output logic             req_q,
  output logic             reject
);
  logic             ack_s1, ack_s2;
  logic [SEL_W-1:0] sel_n;
  logic             run_n, busy_n, pend_n, req_n;

  always_comb begin
    sel_n  = sel_q;
    run_n  = run_q;
    busy_n = busy_q;
    pend_n = pend_q;
    req_n  = req_q;
    if (busy_q && (ack_s2 == req_q)) begin
      busy_n = 1'b0;
      run_n  = pend_q;
    end
    if (wr_hit && !busy_q) begin
      if (!run_q) sel_n = wsel;
      if (wrun != run_q) begin
        pend_n = wrun;
        req_n  = ~req_q;
        busy_n = 1'b1;
      end
    end
  end

  assign reject = wr_hit & busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_s1 <= 1'b0;
      ack_s2 <= 1'b0;
      sel_q  <= '0;
      run_q  <= 1'b0;
      busy_q <= 1'b0;
      pend_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      ack_s1 <= ack_tgl;
      ack_s2 <= ack_s1;
      sel_q  <= sel_n;
      run_q  <= run_n;
      busy_q <= busy_n;
      pend_q <= pend_n;
      req_q  <= req_n;
    end
  end
endmodule

// File: rtl/pclk_chan_gclk.sv
module pclk_chan_gclk #(
  parameter int unsigned N_GEN = 8,
  localparam int unsigned SEL_W = (N_GEN > 1) ? $clog2(N_GEN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_tgl,
  input  logic             pend_run,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [N_GEN-1:0] gen_on,
  output logic             ack_q,
  output logic             run_g,
  output logic             ce_q
);
  logic             req_s1, req_s2;
  logic [SEL_W-1:0] sel_g;
  logic             evt, run_n, ce_n;
  logic [SEL_W-1:0] sel_n;

  always_comb begin
    evt   = req_s2 ^ ack_q;
    run_n = evt ? pend_run : run_g;
    sel_n = evt ? sel_i : sel_g;
    ce_n  = run_g & gen_on[sel_g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_s1 <= 1'b0;
      req_s2 <= 1'b0;
      ack_q  <= 1'b0;
      run_g  <= 1'b0;
      sel_g  <= '0;
      ce_q   <= 1'b0;
    end else begin
      req_s1 <= req_tgl;
      req_s2 <= req_s1;
      ack_q  <= req_s2;
      run_g  <= run_n;
      sel_g  <= sel_n;
      ce_q   <= ce_n;
    end
  end
endmodule

// File: rtl/pclk_chan_ctrl.sv
module pclk_chan_ctrl #(
  parameter int unsigned N_GEN  = pclk_pkg::DEF_GENS,
  parameter int unsigned N_CHAN = pclk_pkg::DEF_CHANS,
  localparam int unsigned SEL_W  = (N_GEN > 1) ? $clog2(N_GEN) : 1,
  localparam int unsigned ADDR_W = (N_CHAN > 1) ? $clog2(N_CHAN) : 1
) (
  input  logic              bus_clk,
  input  logic              bus_rst_n,
  input  logic              gclk,
  input  logic              gclk_rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic              wr_run_i,
  output logic              wr_err_o,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [SEL_W-1:0]  rd_sel_o,
  output logic              rd_run_o,
  output logic              rd_busy_o,
  input  logic [N_GEN-1:0]  gen_on_i,
  output logic [N_CHAN-1:0] chan_ce_o
);
  logic                             brst_n, grst_n;
  logic [N_CHAN-1:0][SEL_W-1:0]     sel_vec;
  logic [N_CHAN-1:0]                run_vec, busy_vec, pend_vec, req_vec, ack_vec, rej_vec, run_g_vec;
  logic                             err_n;

  pclk_rst_sync u_brst (.clk(bus_clk), .arst_n(bus_rst_n),  .rst_n(brst_n));
  pclk_rst_sync u_grst (.clk(gclk),    .arst_n(gclk_rst_n), .rst_n(grst_n));

  for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
    logic hit;
    assign hit = wr_en_i && (wr_addr_i == ADDR_W'(c));

    pclk_chan_bus #(.SEL_W(SEL_W)) u_bus (
      .clk(bus_clk), .rst_n(brst_n), .wr_hit(hit), .wsel(wr_sel_i),
      .wrun(wr_run_i), .ack_tgl(ack_vec[c]), .sel_q(sel_vec[c]),
      .run_q(run_vec[c]), .busy_q(busy_vec[c]), .pend_q(pend_vec[c]),
      .req_q(req_vec[c]), .reject(rej_vec[c])
    );

    pclk_chan_gclk #(.N_GEN(N_GEN)) u_gclk (
      .clk(gclk), .rst_n(grst_n), .req_tgl(req_vec[c]),
      .pend_run(pend_vec[c]), .sel_i(sel_vec[c]), .gen_on(gen_on_i),
      .ack_q(ack_vec[c]), .run_g(run_g_vec[c]), .ce_q(chan_ce_o[c])
    );
  end

  always_comb begin
    err_n = wr_err_o;
    if (wr_en_i) err_n = |rej_vec;
  end

  always_ff @(posedge bus_clk or negedge brst_n) begin
    if (!brst_n) wr_err_o <= 1'b0;
    else         wr_err_o <= err_n;
  end

  assign rd_sel_o  = sel_vec[rd_addr_i];
  assign rd_run_o  = run_vec[rd_addr_i];
  assign rd_busy_o = busy_vec[rd_addr_i];
endmodule

// File: rtl/pclk_chan_ctrl_chk.sv
module pclk_chan_ctrl_chk #(
  parameter int unsigned N_GEN  = 8,
  parameter int unsigned N_CHAN = 16,
  localparam int unsigned SEL_W  = (N_GEN > 1) ? $clog2(N_GEN) : 1,
  localparam int unsigned ADDR_W = (N_CHAN > 1) ? $clog2(N_CHAN) : 1
) (
  input logic                         bus_clk,
  input logic                         bus_rst_n,
  input logic                         gclk,
  input logic                         gclk_rst_n,
  input logic                         wr_en_i,
  input logic [ADDR_W-1:0]            wr_addr_i,
  input logic                         wr_err_o,
  input logic [N_CHAN-1:0][SEL_W-1:0] sel_vec,
  input logic [N_CHAN-1:0]            run_vec,
  input logic [N_CHAN-1:0]            busy_vec,
  input logic [N_CHAN-1:0]            run_g_vec,
  input logic [N_CHAN-1:0]            chan_ce_o
);
  // R5: a write to a busy channel is flagged
  a_r5_busy_write_err: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (wr_en_i && busy_vec[wr_addr_i]) |=> wr_err_o);

  // R5: a write to an idle channel is not flagged
  a_r5_idle_write_ok: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (wr_en_i && !busy_vec[wr_addr_i]) |=> !wr_err_o);

  for (genvar c = 0; c < N_CHAN; c++) begin : g_chk
    // R6: select is frozen while running or busy
    a_r6_sel_frozen: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (run_vec[c] || busy_vec[c]) |=> $stable(sel_vec[c]));

    // R4: readback run bit moves only when busy clears
    a_r4_run_on_done: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      !$stable(run_vec[c]) |-> $fell(busy_vec[c]));

    // R3: busy only rises after a write to this channel
    a_r3_busy_from_write: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      $rose(busy_vec[c]) |-> $past(wr_en_i && (wr_addr_i == ADDR_W'(c))));

    // R7: clock enable drops after the synchronized run bit drops
    a_r7_ce_follows_run: assert property (@(posedge gclk) disable iff (!gclk_rst_n)
      $fell(run_g_vec[c]) |=> !chan_ce_o[c]);
  end
endmodule

bind pclk_chan_ctrl pclk_chan_ctrl_chk #(.N_GEN(N_GEN), .N_CHAN(N_CHAN)) u_chk (
  .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .gclk(gclk), .gclk_rst_n(gclk_rst_n),
  .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_err_o(wr_err_o),
  .sel_vec(sel_vec), .run_vec(run_vec), .busy_vec(busy_vec),
  .run_g_vec(run_g_vec), .chan_ce_o(chan_ce_o)
);

// File: tb/tb_pclk_chan_ctrl.sv
`timescale 1ns/1ps
module tb_pclk_chan_ctrl;
  localparam int NG = 8;
  localparam int NC = 16;

  logic bus_clk = 0, gclk = 0, bus_rst_n = 0, gclk_rst_n = 0;
  logic wr_en = 0, wr_run = 0, wr_err, rd_run, rd_busy;
  logic [3:0] wr_addr = 0, rd_addr = 0;
  logic [2:0] wr_sel = 0, rd_sel;
  logic [NG-1:0] gen_on = 0;
  logic [NC-1:0] ce;

  int n_chk = 0, n_fail = 0;
  int m_sel [NC];
  bit m_run [NC];

  always #2.5  bus_clk = ~bus_clk;
  always #3.65 gclk = ~gclk;

  pclk_chan_ctrl dut (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .gclk(gclk), .gclk_rst_n(gclk_rst_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_sel_i(wr_sel), .wr_run_i(wr_run),
    .wr_err_o(wr_err), .rd_addr_i(rd_addr), .rd_sel_o(rd_sel), .rd_run_o(rd_run),
    .rd_busy_o(rd_busy), .gen_on_i(gen_on), .chan_ce_o(ce)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_ce(int c);
    return m_run[c] && gen_on[m_sel[c]];
  endfunction

  task automatic check_all_ce(string req);
    repeat (4) @(negedge gclk);
    for (int c = 0; c < NC; c++)
      chk(ce[c] == exp_ce(c), req, int'(ce[c]), int'(exp_ce(c)));
  endtask

  task automatic drive_write(int ch, int sel, bit run);
    @(negedge bus_clk);
    wr_en = 1; wr_addr = 4'(ch); wr_sel = 3'(sel); wr_run = run;
    @(negedge bus_clk);
    wr_en = 0; rd_addr = 4'(ch);
    #1;
  endtask

  task automatic write_check(int ch, int sel, bit run);
    bit old = m_run[ch];
    int esel = m_run[ch] ? m_sel[ch] : sel;
    int n = 0;
    drive_write(ch, sel, run);
    chk(wr_err == 0, "R5 idle write err", int'(wr_err), 0);
    chk(rd_sel == 3'(esel), "R2/R6 select readback", int'(rd_sel), esel);
    if (run != old) begin
      chk(rd_busy == 1, "R3 busy set", int'(rd_busy), 1);
      while (rd_busy && n < 100) begin
        chk(rd_run == old, "R3 old run while busy", int'(rd_run), int'(old));
        @(negedge bus_clk); #1; n++;
      end
      chk(n >= 4, "R4 busy length", n, 4);
    end else begin
      chk(rd_busy == 0, "R8 no handshake", int'(rd_busy), 0);
    end
    chk(rd_run == run, "R4 new run after busy", int'(rd_run), int'(run));
    m_sel[ch] = esel; m_run[ch] = run;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1));
    for (int c = 0; c < NC; c++) begin m_sel[c] = 0; m_run[c] = 0; end
    repeat (3) @(negedge bus_clk);
    bus_rst_n = 1; gclk_rst_n = 1;
    repeat (6) @(negedge gclk);
    // R1: reset state
    for (int c = 0; c < NC; c++) begin
      rd_addr = 4'(c); #1;
      chk(rd_sel == 0 && rd_run == 0 && rd_busy == 0, "R1 reset readback",
          int'({rd_sel, rd_run, rd_busy}), 0);
    end
    chk(ce == 0, "R1 reset ce", int'(ce), 0);

    // R7: generator off keeps ce low
    write_check(2, 5, 1);
    check_all_ce("R7 gen off ce low");
    @(negedge gclk); gen_on[5] = 1;
    check_all_ce("R7 gen on ce high");

    // R6: select change on running channel ignored, R8 no handshake
    write_check(2, 1, 1);
    // R6: stop with new select keeps old select
    write_check(2, 3, 0);
    check_all_ce("R9 ce after stop");

    // R5: write to busy channel refused
    drive_write(3, 2, 1);
    drive_write(3, 6, 0);
    chk(wr_err == 1, "R5 busy write err", int'(wr_err), 1);
    repeat (40) @(negedge bus_clk);
    #1;
    chk(rd_run == 1 && rd_sel == 2, "R5 busy write ignored", int'({rd_sel, rd_run}), 5);
    m_sel[3] = 2; m_run[3] = 1;
    drive_write(4, 0, 0);
    chk(wr_err == 0, "R5 err clears on idle write", int'(wr_err), 0);

    // R2/R9: every generator on distinct channels
    for (int g = 0; g < NG; g++) write_check(8 + g, g, 1);
    @(negedge gclk); gen_on = 8'hA5;
    check_all_ce("R7 R9 pattern A5");

    // random mix
    for (int i = 0; i < 80; i++) begin
      write_check(int'($urandom_range(NC - 1)), int'($urandom_range(NG - 1)), 1'($urandom_range(1)));
      if (i % 8 == 0) begin @(negedge gclk); gen_on = 8'($urandom); end
      check_all_ce("R7 R9 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule